// File: doc/BRIEF.md
# Offset-Gain Sigma-Delta Test Converter

This block turns a 16-bit signed demodulator filter sample into a one-bit, high-rate bitstream. An external low-pass filter can rebuild the waveform from that bitstream, so the filter output can be watched from outside the chip. The block has two sample sources, a linear-demodulator result and a correlator-demodulator result, and a configuration bit picks one of them. The chosen sample has a programmable constant removed from it, for example a residual IF term. It is then scaled by a programmable power of two and clipped to the signed 16-bit range. A second-order error-feedback sigma-delta loop then converts the scaled value to a single output bit.

Configuration arrives over a small write port with a 2-bit address. The conditioned level is captured only on the sample strobe. The modulator steps only on its own clock enable, so the two rates are independent. The conditioned level is also brought out on a port, which lets the scaling be observed directly.

Top module: `tdac_sigma_delta`

## Requirements
- R1: After synchronous reset the converter is disabled, the source is the linear input, offset and gain are zero, `dac_bit` is 0 and `dac_level` is 0.
- R2: A write with `cfg_addr`=0 sets enable from `cfg_wdata[0]` and source from `cfg_wdata[1]` (0 selects linear, 1 selects correlator). A write to address 1 sets the 16-bit signed offset. A write to address 2 sets the gain from `cfg_wdata[3:0]`. A write to address 3 changes nothing.
- R3: The source bit picks which of `lin_sample` and `cor_sample` feeds the conversion. The other input has no effect.
- R4: On a strobe, the level becomes (sample − offset)·2^g, where g is the gain code 0..15 and code 0 means unity.
- R5: A scaled result above 32767 is stored as 32767, and one below −32768 is stored as −32768. Values clip and never wrap.
- R6: `dac_level` changes only on a clock edge where `samp_stb` is 1. Sample or configuration changes without a strobe leave it unchanged.
- R7: While enable is 0, `dac_bit` is 0 from the next edge and the loop error state is cleared.
- R8: While enabled, the modulator state and `dac_bit` advance only on edges where `mod_ce` is 1.
- R9: On the first modulator step after a restart from the cleared state, `dac_bit` is 1 if the level is ≥ 0 and 0 otherwise.
- R10: From a restart with a constant level x, where |x| ≤ 16384, the number of ones in any N modulator steps is within 2 of N·(x+32768)/65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration field address |
| cfg_wdata | input | 16 | Configuration write data |
| samp_stb | input | 1 | Captures a new conditioned level |
| lin_sample | input | 16 | Linear-demodulator sample, signed |
| cor_sample | input | 16 | Correlator-demodulator sample, signed |
| mod_ce | input | 1 | Modulator step enable |
| dac_bit | output | 1 | Sigma-delta output bit |
| dac_level | output | 16 | Conditioned modulator input, signed |

## Verification
The scaling path is swept over every gain code and both sources. The samples used are zero, ±1, mid-range values and both extremes, each against several offsets. The extremes separate clipping from wrap-around, and the unused source is driven with a different value so a wrong mux choice shows up. The modulator is run from a fresh restart with levels of zero, small and large positive, and negative. The first bit checks the sign decision. The ones count over each window distinguishes correct second-order feedback from wrong feedback polarity, wrong scaling or a missing error clear.

// File: rtl/tdac_pkg.sv
package tdac_pkg;

    localparam int SAMP_W  = 16;
    localparam int GAIN_W  = 4;
    localparam int ADDR_W  = 2;
    localparam int GUARD_W = 4;
    localparam int MAX_SH  = (1 << GAIN_W) - 1;
    localparam int WIDE_W  = SAMP_W + 1 + MAX_SH;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL  = 2'd0,
        REG_OFFS  = 2'd1,
        REG_GAIN  = 2'd2,
        REG_SPARE = 2'd3
    } reg_addr_e;

    typedef enum logic {
        SRC_LINEAR = 1'b0,
        SRC_CORR   = 1'b1
    } src_sel_e;

    typedef struct packed {
        logic                     enable;
        src_sel_e                 src;
        logic signed [SAMP_W-1:0] offset;
        logic [GAIN_W-1:0]        gain;
    } tdac_cfg_t;

    function automatic logic signed [SAMP_W-1:0] clip_to_sample(
        input logic signed [WIDE_W-1:0] wide
    );
        logic signed [WIDE_W-1:0] hi;
        logic signed [WIDE_W-1:0] lo;
        hi = '0;
        hi[SAMP_W-2:0] = '1;
        lo = '1;
        lo[SAMP_W-2:0] = '0;
        if (wide > hi)
            return hi[SAMP_W-1:0];
        else if (wide < lo)
            return lo[SAMP_W-1:0];
        else
            return wide[SAMP_W-1:0];
    endfunction

endpackage

// File: rtl/tdac_cfg_regs.sv
module tdac_cfg_regs
    import tdac_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [SAMP_W-1:0]   wdata,
    output tdac_cfg_t           cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we) begin
            case (reg_addr_e'(addr))
                REG_CTRL: begin
                    cfg.enable <= wdata[0];
                    cfg.src    <= src_sel_e'(wdata[1]);
                end
                REG_OFFS: cfg.offset <= wdata;
                REG_GAIN: cfg.gain   <= wdata[GAIN_W-1:0];
                default: ;
            endcase
        end
    end

    // R2: gain field lands from the low data bits
    p_gain_write_r2: assert property (@(posedge clk) disable iff (rst)
        (we && addr == REG_GAIN) |=> (cfg.gain == $past(wdata[GAIN_W-1:0])));

    // R2: spare address leaves every field untouched
    p_spare_ignored_r2: assert property (@(posedge clk) disable iff (rst)
        (we && addr == REG_SPARE) |=> (cfg == $past(cfg)));

endmodule

// File: rtl/tdac_level_path.sv
module tdac_level_path
    import tdac_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     stb,
    input  logic signed [SAMP_W-1:0] lin,
    input  logic signed [SAMP_W-1:0] cor,
    input  tdac_cfg_t                cfg,
    output logic signed [SAMP_W-1:0] level
);

    logic signed [SAMP_W-1:0] picked;
    logic signed [SAMP_W:0]   diff;
    logic signed [WIDE_W-1:0] diff_w;
    logic signed [WIDE_W-1:0] scaled;

    always_comb begin
        picked = (cfg.src == SRC_CORR) ? cor : lin;
        diff   = {picked[SAMP_W-1], picked} - {cfg.offset[SAMP_W-1], cfg.offset};
        diff_w = {{(WIDE_W-SAMP_W-1){diff[SAMP_W]}}, diff};
        scaled = diff_w <<< cfg.gain;
    end

    always_ff @(posedge clk) begin
        if (rst)
            level <= '0;
        else if (stb)
            level <= clip_to_sample(scaled);
    end

    // R6: level holds between strobes
    p_level_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !stb |=> $stable(level));

    // R4: a sample equal to the offset yields zero at any gain
    p_offset_cancel_r4: assert property (@(posedge clk) disable iff (rst)
        (stb && picked == cfg.offset) |=> (level == '0));

endmodule

// File: rtl/tdac_sdm2.sv
module tdac_sdm2
    import tdac_pkg::*;
#(
    parameter int IN_W = SAMP_W,
    parameter int GRD_W = GUARD_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   en,
    input  logic                   ce,
    input  logic signed [IN_W-1:0] x,
    output logic                   bit_o
);

    localparam int IW = IN_W + GRD_W;
    localparam logic signed [IW-1:0] FS = IW'(1) <<< (IN_W - 1);

    logic signed [IW-1:0] e1, e2;
    logic signed [IW-1:0] x_w, v, fb, e_new;
    logic                 y;

    always_comb begin
        x_w   = {{GRD_W{x[IN_W-1]}}, x};
        v     = x_w + (e1 <<< 1) - e2;
        y     = ~v[IW-1];
        fb    = y ? FS : -FS;
        e_new = v - fb;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            e1    <= '0;
            e2    <= '0;
            bit_o <= 1'b0;
        end else if (ce) begin
            e2    <= e1;
            e1    <= e_new;
            bit_o <= y;
        end
    end

    // R7: output forced low once disabled
    p_off_low_r7: assert property (@(posedge clk) disable iff (rst)
        !en |=> !bit_o);

    // R8: no step without the clock enable
    p_hold_no_ce_r8: assert property (@(posedge clk) disable iff (rst)
        (en && !ce) |=> $stable(bit_o));

    // R7: error state clears while disabled
    p_err_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (!en && $past(!en)) |-> (e1 == '0 && e2 == '0));

endmodule

// File: rtl/tdac_sigma_delta.sv
module tdac_sigma_delta
    import tdac_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_addr,
    input  logic [15:0]        cfg_wdata,
    input  logic               samp_stb,
    input  logic [15:0]        lin_sample,
    input  logic [15:0]        cor_sample,
    input  logic               mod_ce,
    output logic               dac_bit,
    output logic [15:0]        dac_level
);

    tdac_cfg_t                cfg;
    logic signed [SAMP_W-1:0] level;

    tdac_cfg_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    tdac_level_path u_path (
        .clk   (clk),
        .rst   (rst),
        .stb   (samp_stb),
        .lin   (lin_sample),
        .cor   (cor_sample),
        .cfg   (cfg),
        .level (level)
    );

    tdac_sdm2 #(.IN_W(SAMP_W), .GRD_W(GUARD_W)) u_mod (
        .clk   (clk),
        .rst   (rst),
        .en    (cfg.enable),
        .ce    (mod_ce),
        .x     (level),
        .bit_o (dac_bit)
    );

    assign dac_level = level;

    // R1: reset leaves outputs at rest
    p_reset_rest_r1: assert property (@(posedge clk)
        rst |=> (!dac_bit && dac_level == '0));

endmodule

// File: tb/tdac_sigma_delta_tb_top.sv
module tdac_sigma_delta_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        samp_stb = 1'b0;
    logic [15:0] lin_sample = '0;
    logic [15:0] cor_sample = '0;
    logic        mod_ce = 1'b0;
    logic        dac_bit;
    logic [15:0] dac_level;

    int pass_cnt = 0;
    int fail_cnt = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tdac_sigma_delta dut_i (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .samp_stb(samp_stb), .lin_sample(lin_sample),
        .cor_sample(cor_sample), .mod_ce(mod_ce), .dac_bit(dac_bit),
        .dac_level(dac_level)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        if (ok) pass_cnt++;
        else begin
            fail_cnt++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic strobe(input longint lv, input longint cv);
        @(negedge clk);
        lin_sample = 16'(lv); cor_sample = 16'(cv); samp_stb = 1'b1;
        @(negedge clk);
        samp_stb = 1'b0;
    endtask

    function automatic longint exp_level(input longint s, input longint off, input int g);
        longint d;
        d = (s - off) * (longint'(1) <<< g);
        if (d > 32767) d = 32767;
        if (d < -32768) d = -32768;
        return d;
    endfunction

    task automatic run_density(input longint x, input int n);
        longint ones = 0;
        longint lhs, rhs, dif;
        wr(2'd0, 16'h0000);
        mod_ce = 1'b0;
        wr(2'd1, 16'h0000);
        wr(2'd2, 16'h0000);
        strobe(x, 0);
        @(negedge clk);
        check(dac_bit == 1'b0, "R7 off", dac_bit, 0);
        wr(2'd0, 16'h0001);
        mod_ce = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == 0) check(dac_bit == (x >= 0), "R9 first bit", dac_bit, (x >= 0));
            ones += dac_bit;
        end
        mod_ce = 1'b0;
        lhs = ones * 65536;
        rhs = longint'(n) * (x + 32768);
        dif = lhs - rhs;
        if (dif < 0) dif = -dif;
        check(dif <= 2 * 65536, "R10 density", ones, rhs / 65536);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fail_cnt++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
            $finish;
        end
    end

    initial begin
        int offs[3];
        longint samps[8];
        offs = '{0, 5000, -7};
        samps = '{0, 1, -1, 100, -100, 32767, -32768, 12345};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(dac_bit == 1'b0, "R1 bit", dac_bit, 0);
        check(dac_level == 16'd0, "R1 level", dac_level, 0);
        mod_ce = 1'b1;
        strobe(1234, -999);
        repeat (3) @(negedge clk);
        check(dac_bit == 1'b0, "R1 disabled", dac_bit, 0);
        check($signed(dac_level) == 1234, "R1 default cfg", $signed(dac_level), 1234);
        mod_ce = 1'b0;

        // R3 R4 R5 sweep
        for (int src = 0; src < 2; src++) begin
            wr(2'd0, 16'(src << 1));
            foreach (offs[o]) begin
                wr(2'd1, 16'(offs[o]));
                for (int g = 0; g < 16; g++) begin
                    wr(2'd2, 16'(g));
                    foreach (samps[k]) begin
                        longint s, other, e;
                        s = samps[k];
                        other = (s == 0) ? 777 : -s / 2 + 3;
                        if (src == 1) strobe(other, s); else strobe(s, other);
                        e = exp_level(s, offs[o], g);
                        check($signed(dac_level) == e, "R3 R4 R5 level", $signed(dac_level), e);
                    end
                end
            end
        end

        // R6: no strobe, level stays
        wr(2'd0, 16'h0000);
        wr(2'd1, 16'd0);
        wr(2'd2, 16'd0);
        strobe(-4321, 0);
        @(negedge clk);
        lin_sample = 16'd9999;
        wr(2'd1, 16'd50);
        wr(2'd2, 16'd3);
        repeat (2) @(negedge clk);
        check($signed(dac_level) == -4321, "R6 hold", $signed(dac_level), -4321);

        // R2: spare address ignored
        wr(2'd3, 16'hFFFF);
        strobe(150, 0);
        check($signed(dac_level) == 800, "R2 spare", $signed(dac_level), 800);
        wr(2'd0, 16'h0002);
        strobe(0, 11);
        check($signed(dac_level) == -312, "R2 ctrl src", $signed(dac_level), -312);

        // R7 R9 R10
        run_density(0, 4096);
        run_density(5000, 4096);
        run_density(-12000, 4096);
        run_density(300, 4096);
        run_density(-16384, 4096);

        // R8: enabled, no clock enable
        begin
            logic held;
            held = dac_bit;
            repeat (6) @(negedge clk);
            check(dac_bit == held, "R8 hold", dac_bit, held);
        end

        run_density(16384, 65536);

        wr(2'd0, 16'h0000);
        @(negedge clk);
        check(dac_bit == 1'b0, "R7 disable", dac_bit, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
        $finish;
    end

endmodule